// File: doc/BRIEF.md
# Storage-Key Protection Checker

This block sits in front of a CPU's memory port and decides whether each access may go ahead. An access is a fetch or a store of one byte, a halfword or a full word at a physical address. The requester supplies the access key taken from its program status word and two feature enables: one for key protection and one for unaligned access. Memory is divided into 2 KiB blocks, and each block has a storage key. A key holds a 4-bit access key and a fetch-protect flag. Address translation is treated as identity, so the request address is already physical.

Each request gets exactly one verdict: grant, protection exception or specification exception. An unaligned access may spill into the following word. When that word opens a new 2 KiB block, the key of that second block is checked as well. Keys are loaded through a separate set-key port.

Requests enter on a valid/ready handshake and verdicts leave on another. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and its verdict appears with `resp_valid` on the next cycle. `req_ready` is high whenever the output holds nothing or the output is being taken that cycle. While `resp_ready` is low, the verdict and `resp_valid` hold steady and no new request is accepted. The request fields are sampled only on the accepting edge.

Top module: `storage_key_checker`

## Requirements
- R1: After reset `resp_valid` is low, `req_ready` is high, and every block key reads as access key 0 with fetch-protect clear.
- R2: A request accepted on edge N gives `resp_valid` high after edge N. While `resp_ready` is low the verdict and `resp_valid` stay unchanged and `req_ready` is low.
- R3: Every verdict with `resp_valid` high has exactly one of `resp_grant`, `resp_prot`, `resp_spec` set.
- R4: A request key of 0 skips all key checks. Such an access is granted unless it raises a specification exception.
- R5: A nonzero request key with `prot_en` low raises a protection exception on every access, whatever the block keys hold.
- R6: A store is denied when the block's access key differs from the request key.
- R7: A fetch is denied only when the block's fetch-protect flag is set and its access key differs from the request key.
- R8: With `unal_en` low, two cases raise a specification exception: a word access (`req_size` 2'b10) at an address whose low two bits are not 00, and a halfword access (`req_size` 2'b01) at an odd address. Byte accesses (`req_size` 2'b00) never do. `req_size` 2'b11 is handled as a word.
- R9: When a specification exception and a protection exception arise for the same request, only `resp_spec` is reported.
- R10: Two accesses spill into the next word: a word at a nonzero byte offset, and a halfword at byte offset 3. The next word's address is the request address plus 4. If its bits 10:2 are all zero, the key of the block holding that word is checked with the same rules.
- R11: When the next word's bits 10:2 are not all zero, only the first block's key is checked.
- R12: The block key index is address bits above bit 10. A key written on `key_we` at edge N applies to requests accepted on edges after N. A request accepted on edge N still sees the old key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W (16) | Physical byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 treated as word |
| req_store | input | 1 | 1 store, 0 fetch |
| req_key | input | 4 | Access key of the requester, 0 bypasses checks |
| prot_en | input | 1 | Key protection feature present |
| unal_en | input | 1 | Unaligned access feature present |
| resp_valid | output | 1 | Verdict present |
| resp_ready | input | 1 | Verdict taken this cycle |
| resp_grant | output | 1 | Access allowed |
| resp_prot | output | 1 | Protection exception |
| resp_spec | output | 1 | Specification exception |
| key_we | input | 1 | Write one block key |
| key_idx | input | ADDR_W-11 (5) | Block index to write |
| key_acc | input | 4 | Access key value to write |
| key_fprot | input | 1 | Fetch-protect flag to write |

## Verification
The table of vectors runs fetches and stores against blocks with different keys, with and without the fetch-protect flag. This separates the fetch rule from the store rule. Misaligned words, odd and even halfwords and bytes are run with the unaligned feature off, which shows which sizes raise specification exceptions. One case combines misalignment with a key mismatch to show which exception wins. Accesses just below a 2 KiB boundary show whether the second block's key is consulted. These are a word at offset 1 and a halfword at offset 3, each set against a nearby access that stays in its block. A mismatching key is placed in the next block, so only the spill check can deny these accesses. Directed tests cover the reset keys, verdicts held under back-pressure, and a key write that lands on the same edge as a request.

// File: rtl/skl_pkg.sv
package skl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic grant;
    logic prot;
    logic spec;
  } verdict_t;
endpackage

// File: rtl/skl_key_table.sv
module skl_key_table #(
  parameter int NBLK  = 32,
  parameter int IDX_W = 5,
  parameter int PKEY_W = 4,
  parameter int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PKEY_W-1:0] wr_acc,
  input  logic              wr_fprot,
  input  logic [IDX_W-1:0]  rd_idx   [NPORT],
  output logic [PKEY_W-1:0] rd_acc   [NPORT],
  output logic              rd_fprot [NPORT]
);
  logic [PKEY_W-1:0] acc_q   [NBLK];
  logic              fprot_q [NBLK];

  // One register per block; reset clears key and fetch-protect flag
  for (genvar b = 0; b < NBLK; b++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[b]   <= '0;
        fprot_q[b] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(b))) begin
        acc_q[b]   <= wr_acc;
        fprot_q[b] <= wr_fprot;
      end
    end
  end

  // Combinational read ports: a same-edge write is not yet visible
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rd_acc[p]   = acc_q[rd_idx[p]];
    assign rd_fprot[p] = fprot_q[rd_idx[p]];
  end
endmodule

// File: rtl/skl_align.sv
module skl_align
  import skl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_SHIFT = 11,
  localparam int IDX_W    = ADDR_W - BLK_SHIFT,
  localparam int WADDR_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  input  logic              unal_en,
  output logic              spec,
  output logic              spill_chk,
  output logic [IDX_W-1:0]  idx_first,
  output logic [IDX_W-1:0]  idx_next
);
  logic [1:0]         off;
  logic               misalign;
  logic               spills;
  logic [WADDR_W-1:0] next_word;

  assign off = addr[1:0];

  always_comb begin
    unique case (size)
      SZ_BYTE: begin misalign = 1'b0;        spills = 1'b0;        end
      SZ_HALF: begin misalign = off[0];      spills = (off == 2'd3); end
      default: begin misalign = (off != 2'd0); spills = (off != 2'd0); end
    endcase
  end

  // Word address of the word after the one addressed (wraps modulo memory)
  assign next_word = addr[ADDR_W-1:2] + WADDR_W'(1);

  assign spec      = misalign && !unal_en;
  assign spill_chk = spills && (next_word[BLK_SHIFT-3:0] == '0);
  assign idx_first = addr[ADDR_W-1:BLK_SHIFT];
  assign idx_next  = next_word[WADDR_W-1:BLK_SHIFT-2];
endmodule

// File: rtl/skl_key_cmp.sv
module skl_key_cmp #(
  parameter int PKEY_W = 4
) (
  input  logic [PKEY_W-1:0] blk_acc,
  input  logic              blk_fprot,
  input  logic [PKEY_W-1:0] req_key,
  input  logic              is_store,
  output logic              deny
);
  logic mismatch;
  assign mismatch = (blk_acc != req_key);
  // Stores need a matching key; fetches only when the block is fetch-protected
  assign deny = mismatch && (is_store || blk_fprot);
endmodule

// File: rtl/storage_key_checker.sv
module storage_key_checker
  import skl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_SHIFT = 11,
  parameter int PKEY_W    = 4,
  localparam int IDX_W    = ADDR_W - BLK_SHIFT,
  localparam int NBLK     = 1 << IDX_W,
  localparam int NPORT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_store,
  input  logic [PKEY_W-1:0] req_key,
  input  logic              prot_en,
  input  logic              unal_en,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_grant,
  output logic              resp_prot,
  output logic              resp_spec,
  input  logic              key_we,
  input  logic [IDX_W-1:0]  key_idx,
  input  logic [PKEY_W-1:0] key_acc,
  input  logic              key_fprot
);
  logic              spec;
  logic              spill_chk;
  logic [IDX_W-1:0]  rd_idx   [NPORT];
  logic [PKEY_W-1:0] rd_acc   [NPORT];
  logic              rd_fprot [NPORT];
  logic [NPORT-1:0]  deny;
  logic              prot;
  logic              fire;
  verdict_t          verdict_d, verdict_q;
  logic              valid_q;

  skl_align #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_align (
    .addr      (req_addr),
    .size      (acc_size_e'(req_size)),
    .unal_en   (unal_en),
    .spec      (spec),
    .spill_chk (spill_chk),
    .idx_first (rd_idx[0]),
    .idx_next  (rd_idx[1])
  );

  skl_key_table #(.NBLK(NBLK), .IDX_W(IDX_W), .PKEY_W(PKEY_W), .NPORT(NPORT)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (key_we),
    .wr_idx   (key_idx),
    .wr_acc   (key_acc),
    .wr_fprot (key_fprot),
    .rd_idx   (rd_idx),
    .rd_acc   (rd_acc),
    .rd_fprot (rd_fprot)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_cmp
    skl_key_cmp #(.PKEY_W(PKEY_W)) u_cmp (
      .blk_acc   (rd_acc[p]),
      .blk_fprot (rd_fprot[p]),
      .req_key   (req_key),
      .is_store  (req_store),
      .deny      (deny[p])
    );
  end

  // Key 0 bypasses; missing protection feature denies any nonzero key
  always_comb begin
    if (req_key == '0)    prot = 1'b0;
    else if (!prot_en)    prot = 1'b1;
    else                  prot = deny[0] || (spill_chk && deny[1]);
  end

  always_comb begin
    verdict_d.spec  = spec;
    verdict_d.prot  = prot && !spec;
    verdict_d.grant = !spec && !prot;
  end

  assign req_ready = !valid_q || resp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      verdict_q <= '0;
    end else if (fire) begin
      valid_q   <= 1'b1;
      verdict_q <= verdict_d;
    end else if (resp_ready) begin
      valid_q   <= 1'b0;
    end
  end

  assign resp_valid = valid_q;
  assign resp_grant = verdict_q.grant;
  assign resp_prot  = verdict_q.prot;
  assign resp_spec  = verdict_q.spec;
endmodule

// File: rtl/skl_checker.sv
module skl_checker #(
  parameter int PKEY_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_off,
  input logic [1:0]        req_size,
  input logic [PKEY_W-1:0] req_key,
  input logic              prot_en,
  input logic              unal_en,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_grant,
  input logic              resp_prot,
  input logic              resp_spec
);
  logic fire;
  assign fire = req_valid && req_ready;

  assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_grant, resp_prot, resp_spec}) == 1));

  assert_fire_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> resp_valid);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable({resp_grant, resp_prot, resp_spec})));

  assert_zero_key_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_key == '0 && req_off == 2'd0) |=> resp_grant);

  assert_no_feature_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_key != '0 && !prot_en && req_size == 2'b00) |=> resp_prot);

  assert_word_misalign_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_size == 2'b10 && req_off != 2'd0 && !unal_en) |=> resp_spec);

  assert_byte_no_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_size == 2'b00) |=> !resp_spec);
endmodule

bind storage_key_checker skl_checker #(.PKEY_W(PKEY_W)) u_skl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_off    (req_addr[1:0]),
  .req_size   (req_size),
  .req_key    (req_key),
  .prot_en    (prot_en),
  .unal_en    (unal_en),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_grant (resp_grant),
  .resp_prot  (resp_prot),
  .resp_spec  (resp_spec)
);

// File: tb/test_storage_key_checker.sv
module test_storage_key_checker;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 5;
  localparam int NVEC   = 21;
  localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10;
  localparam logic [1:0] EG = 2'd0, EP = 2'd1, ES = 2'd2;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [3:0]  key;
    logic        pe;
    logic        ue;
    logic [1:0]  exp;
    logic [3:0]  rq;
  } vec_t;

  // Blocks: 0 -> key 5, 1 -> key 3 fetch-protected, 2 -> key 7, 3 -> reset value
  localparam vec_t VEC [NVEC] = '{
    {1'b1, H, 16'h0000, 4'd5, 1'b1, 1'b1, EG, 4'd6},   // R6 match
    {1'b1, B, 16'h0800, 4'd5, 1'b1, 1'b1, EP, 4'd6},   // R6 mismatch
    {1'b0, W, 16'h0800, 4'd5, 1'b1, 1'b1, EP, 4'd7},   // R7 fetch-protected
    {1'b0, W, 16'h0000, 4'd7, 1'b1, 1'b1, EG, 4'd7},   // R7 flag clear
    {1'b0, W, 16'h0800, 4'd3, 1'b1, 1'b1, EG, 4'd7},   // R7 match
    {1'b1, W, 16'h1000, 4'd0, 1'b1, 1'b1, EG, 4'd4},   // R4 bypass
    {1'b1, W, 16'h0002, 4'd0, 1'b1, 1'b0, ES, 4'd8},   // R8 word offset 2
    {1'b1, H, 16'h0001, 4'd5, 1'b1, 1'b0, ES, 4'd8},   // R8 odd half
    {1'b1, B, 16'h0003, 4'd5, 1'b1, 1'b0, EG, 4'd8},   // R8 byte
    {1'b1, H, 16'h0002, 4'd5, 1'b1, 1'b0, EG, 4'd8},   // R8 even half
    {1'b1, W, 16'h0801, 4'd5, 1'b1, 1'b0, ES, 4'd9},   // R9 spec over prot
    {1'b1, W, 16'h0000, 4'd5, 1'b0, 1'b1, EP, 4'd5},   // R5 feature off
    {1'b1, W, 16'h07FD, 4'd5, 1'b1, 1'b1, EP, 4'd10},  // R10 store spill
    {1'b0, W, 16'h07FD, 4'd3, 1'b1, 1'b1, EG, 4'd10},  // R10 fetch spill ok
    {1'b0, W, 16'h07FD, 4'd5, 1'b1, 1'b1, EP, 4'd10},  // R10 fetch spill deny
    {1'b1, H, 16'h07FF, 4'd5, 1'b1, 1'b1, EP, 4'd10},  // R10 half offset 3
    {1'b1, H, 16'h07FE, 4'd5, 1'b1, 1'b1, EG, 4'd10},  // R10 half offset 2
    {1'b1, W, 16'h0005, 4'd5, 1'b1, 1'b1, EG, 4'd11},  // R11 inside block
    {1'b1, W, 16'h07F9, 4'd5, 1'b1, 1'b1, EG, 4'd11},  // R11 near edge
    {1'b1, W, 16'h07FC, 4'd5, 1'b1, 1'b1, EG, 4'd11},  // R11 aligned last word
    {1'b1, W, 16'h0002, 4'd0, 1'b0, 1'b1, EG, 4'd4}    // R4 key 0 with feature off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic req_store = 1'b0;
  logic [3:0] req_key = '0;
  logic prot_en = 1'b1, unal_en = 1'b1;
  logic resp_valid, resp_ready = 1'b1;
  logic resp_grant, resp_prot, resp_spec;
  logic key_we = 1'b0;
  logic [IDX_W-1:0] key_idx = '0;
  logic [3:0] key_acc = '0;
  logic key_fprot = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  storage_key_checker i_storage_key_checker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_store(req_store), .req_key(req_key),
    .prot_en(prot_en), .unal_en(unal_en),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_grant(resp_grant), .resp_prot(resp_prot), .resp_spec(resp_spec),
    .key_we(key_we), .key_idx(key_idx), .key_acc(key_acc), .key_fprot(key_fprot)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] code_to_vec(input logic [1:0] c);
    // {valid, grant, prot, spec}
    case (c)
      EG:      return 4'b1100;
      EP:      return 4'b1010;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic write_key(input int idx, input logic [3:0] acc, input logic fp);
    @(negedge clk);
    key_we = 1'b1; key_idx = IDX_W'(idx); key_acc = acc; key_fprot = fp;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic drive(input logic st, input logic [1:0] sz, input logic [15:0] a,
                       input logic [3:0] k, input logic pe, input logic ue);
    req_store = st; req_size = sz; req_addr = a; req_key = k;
    prot_en = pe; unal_en = ue; req_valid = 1'b1;
  endtask

  task automatic do_req(input logic st, input logic [1:0] sz, input logic [15:0] a,
                        input logic [3:0] k, input logic pe, input logic ue,
                        input logic [1:0] exp, input string rq);
    @(negedge clk);
    drive(st, sz, a, k, pe, ue);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, {28'd0, resp_valid, resp_grant, resp_prot, resp_spec}, {28'd0, code_to_vec(exp)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the handshake
    check("R1 reset", {30'd0, resp_valid, req_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {30'd0, resp_valid, req_ready}, 32'd1);

    // R1: untouched block 3 holds key 0, flag clear
    do_req(1'b1, B, 16'h1800, 4'd5, 1'b1, 1'b1, EP, "R1 reset key store");
    do_req(1'b0, B, 16'h1800, 4'd5, 1'b1, 1'b1, EG, "R1 reset key fetch");

    write_key(0, 4'd5, 1'b0);
    write_key(1, 4'd3, 1'b1);
    write_key(2, 4'd7, 1'b0);

    // R3 each vector also checks that one verdict bit alone is set
    for (int i = 0; i < NVEC; i++) begin
      do_req(VEC[i].st, VEC[i].sz, VEC[i].addr, VEC[i].key, VEC[i].pe, VEC[i].ue,
             VEC[i].exp, $sformatf("R%0d/R3 vector %0d", VEC[i].rq, i));
    end

    // R2: back-pressure holds verdict and blocks a new request
    @(negedge clk);
    resp_ready = 1'b0;
    drive(1'b1, B, 16'h0000, 4'd5, 1'b1, 1'b1);
    @(negedge clk);
    check("R2 held valid", {30'd0, resp_valid, req_ready}, 32'd2);
    drive(1'b1, B, 16'h0000, 4'd3, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R2 held verdict", {28'd0, resp_valid, resp_grant, resp_prot, resp_spec}, 32'b1100);
    check("R2 still blocked", {31'd0, req_ready}, 32'd0);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 next accepted", {28'd0, resp_valid, resp_grant, resp_prot, resp_spec}, 32'b1010);

    // R12: index is address above bit 10, write timing
    write_key(2, 4'd9, 1'b0);
    do_req(1'b1, W, 16'h1000, 4'd9, 1'b1, 1'b1, EG, "R12 new key");
    do_req(1'b1, W, 16'h17FC, 4'd9, 1'b1, 1'b1, EG, "R12 top of block");
    do_req(1'b1, W, 16'h1800, 4'd9, 1'b1, 1'b1, EP, "R12 next block");
    @(negedge clk);
    key_we = 1'b1; key_idx = IDX_W'(2); key_acc = 4'd1; key_fprot = 1'b0;
    drive(1'b1, W, 16'h1000, 4'd1, 1'b1, 1'b1);
    @(negedge clk);
    key_we = 1'b0;
    req_valid = 1'b0;
    check("R12 same-edge write unseen", {28'd0, resp_valid, resp_grant, resp_prot, resp_spec}, 32'b1010);
    do_req(1'b1, W, 16'h1000, 4'd1, 1'b1, 1'b1, EG, "R12 write seen later");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule